// File: doc/BRIEF.md
# Hardwired Cycle-Phase Control Generator

This block is the hardwired control unit of a small accumulator machine. It holds a two-bit major-cycle register that moves between fetch, indirect, execute and interrupt. It also holds a phase counter that steps through four minor phases, T1 to T4, inside every major cycle. The incoming opcode is decoded into one-hot instruction lines. Every control strobe is a sum-of-products term over the cycle code, the phase and those instruction lines.

The strobes drive a datapath that sits outside this block. They load the memory address register, load the memory buffer register from the external bus, increment the program counter, load the instruction register and write the accumulator. The instruction decoder upstream holds the opcode and the indirect bit steady. An interrupt controller supplies a request line, which is sampled only at the end of an execute cycle.

Top module: `hwctl_top`

## Requirements
- R1: A synchronous, active-high `rst` puts the unit in the fetch cycle at phase T1 (`cycle` = 00, `phase` = 0). This holds both at power-up and when `rst` is raised in the middle of an instruction.
- R2: `cycle` encodes 00 = fetch, 01 = indirect, 10 = execute and 11 = interrupt. `phase` encodes T1..T4 as 0..3. Each major cycle lasts four clocks. `phase` rises by one each clock, and `cycle` holds its value until the clock after T4. On that clock `phase` returns to T1 and the major cycle changes.
- R3: At the end of T4 in fetch, the next cycle is indirect if `ind_bit` is 1 and execute otherwise. `ind_bit` has no effect in any other cycle or phase.
- R4: Indirect is always followed by execute, and interrupt is always followed by fetch. During the interrupt cycle no strobe is asserted.
- R5: At the end of T4 in execute, the next cycle is interrupt if `irq` is 1 and fetch otherwise. `irq` has no effect in any other cycle or phase.
- R6: `mbr_load` is asserted at T2 of the fetch cycle and at T2 of the indirect cycle, whatever the opcode.
- R7: In the execute cycle, `mbr_load` is asserted only at T2, and only when the opcode is a memory-reading instruction: load 0001, add 0010 or and 0011. It is never asserted at any other execute phase or for any other opcode.
- R8: `mar_load` is asserted at T1 of fetch, at T1 of indirect, and at T1 of execute for the opcodes 0001, 0010 and 0011 only.
- R9: `pc_inc` is asserted only at T2 of fetch. `ir_load` is asserted only at T3 of fetch.
- R10: `acc_load` is asserted only at T3 of execute, and only for the opcodes 0001, 0010 and 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (4) | Opcode of the current instruction |
| ind_bit | input | 1 | Indirect-addressing flag of the current instruction |
| irq | input | 1 | Pending interrupt request |
| mar_load | output | 1 | Load memory address register |
| mbr_load | output | 1 | Load memory buffer register from external data bus |
| pc_inc | output | 1 | Increment program counter |
| ir_load | output | 1 | Load instruction register |
| acc_load | output | 1 | Write accumulator |
| cycle | output | 2 | Current major cycle code |
| phase | output | PH_W (2) | Current minor phase, 0 = T1 |

## Verification
Two things happen in the T4 clock of fetch and of execute. The phase counter wraps, and the major-cycle register chooses its successor from `ind_bit` or `irq`. A mistake in either one moves every later strobe. The bench provokes this overlap by holding `ind_bit` and `irq` at the inverse of the wanted value in every phase except the deciding T4, where it drives the wanted value. It runs this sweep over every opcode and every combination of indirect and interrupt. A reference model in the bench tracks cycle and phase and recomputes every strobe, and each clock's outputs are compared against it.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

    localparam int OP_W_DEF    = 4;
    localparam int PHASE_N_DEF = 4;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } major_e;

    // memory-reading instructions
    localparam int OPC_LOAD = 1;
    localparam int OPC_ADD  = 2;
    localparam int OPC_AND  = 3;

    // minor phase indices (T1..T4)
    localparam int PH_T1 = 0;
    localparam int PH_T2 = 1;
    localparam int PH_T3 = 2;
    localparam int PH_T4 = 3;

    typedef struct packed {
        logic mar_load;
        logic mbr_load;
        logic pc_inc;
        logic ir_load;
        logic acc_load;
    } strobe_t;

    typedef struct packed {
        logic fetch;
        logic indir;
        logic exec;
        logic intr;
    } cyc_lines_t;

    function automatic major_e next_major(input major_e cur, input logic ind, input logic req);
        major_e nxt;
        unique case (cur)
            CYC_FETCH: nxt = ind ? CYC_INDIR : CYC_EXEC;
            CYC_INDIR: nxt = CYC_EXEC;
            CYC_EXEC:  nxt = req ? CYC_INTR : CYC_FETCH;
            default:   nxt = CYC_FETCH;
        endcase
        return nxt;
    endfunction

    function automatic cyc_lines_t decode_cycle(input major_e cur);
        cyc_lines_t l;
        l.fetch = (cur == CYC_FETCH);
        l.indir = (cur == CYC_INDIR);
        l.exec  = (cur == CYC_EXEC);
        l.intr  = (cur == CYC_INTR);
        return l;
    endfunction

endpackage

// File: rtl/hwctl_phase_ctr.sv
module hwctl_phase_ctr #(
    parameter int PHASE_N = hwctl_pkg::PHASE_N_DEF,
    localparam int PH_W   = $clog2(PHASE_N)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASE_N - 1);

    assign last = (phase == LAST_PH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (last) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/hwctl_major_reg.sv
module hwctl_major_reg
    import hwctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  logic   ind_bit,
    input  logic   irq,
    output major_e cyc
);
    major_e cyc_nxt;

    always_comb begin
        cyc_nxt = cyc;
        if (adv) begin
            cyc_nxt = next_major(cyc, ind_bit, irq);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= CYC_FETCH;
        end else begin
            cyc <= cyc_nxt;
        end
    end
endmodule

// File: rtl/hwctl_op_decode.sv
module hwctl_op_decode #(
    parameter int OP_W   = hwctl_pkg::OP_W_DEF,
    localparam int NOPS  = 1 << OP_W
) (
    input  logic [OP_W-1:0] opcode,
    output logic [NOPS-1:0] op_lines
);
    for (genvar i = 0; i < NOPS; i++) begin : g_line
        assign op_lines[i] = (opcode == OP_W'(i));
    end
endmodule

// File: rtl/hwctl_strobe_matrix.sv
module hwctl_strobe_matrix
    import hwctl_pkg::*;
#(
    parameter int OP_W    = OP_W_DEF,
    parameter int PHASE_N = PHASE_N_DEF,
    localparam int NOPS   = 1 << OP_W,
    localparam int PH_W   = $clog2(PHASE_N)
) (
    input  major_e          cyc,
    input  logic [PH_W-1:0] phase,
    input  logic [NOPS-1:0] op_lines,
    output strobe_t         strb
);
    logic [PHASE_N-1:0] t;
    cyc_lines_t         c;
    logic               mem_rd;

    for (genvar k = 0; k < PHASE_N; k++) begin : g_phase
        assign t[k] = (phase == PH_W'(k));
    end

    assign c      = decode_cycle(cyc);
    assign mem_rd = op_lines[OPC_LOAD] | op_lines[OPC_ADD] | op_lines[OPC_AND];

    always_comb begin
        strb.mar_load = (c.fetch & t[PH_T1]) | (c.indir & t[PH_T1])
                      | (c.exec & t[PH_T1] & mem_rd);
        strb.mbr_load = (c.fetch & t[PH_T2]) | (c.indir & t[PH_T2])
                      | (c.exec & t[PH_T2] & mem_rd);
        strb.pc_inc   = c.fetch & t[PH_T2];
        strb.ir_load  = c.fetch & t[PH_T3];
        strb.acc_load = c.exec & t[PH_T3] & mem_rd;
    end
endmodule

// File: rtl/hwctl_top.sv
module hwctl_top
    import hwctl_pkg::*;
#(
    parameter int OP_W    = OP_W_DEF,
    parameter int PHASE_N = PHASE_N_DEF,
    localparam int PH_W   = $clog2(PHASE_N),
    localparam int NOPS   = 1 << OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            ind_bit,
    input  logic            irq,
    output logic            mar_load,
    output logic            mbr_load,
    output logic            pc_inc,
    output logic            ir_load,
    output logic            acc_load,
    output logic [1:0]      cycle,
    output logic [PH_W-1:0] phase
);
    logic            adv;
    major_e          cyc;
    logic [NOPS-1:0] op_lines;
    strobe_t         strb;

    hwctl_phase_ctr #(.PHASE_N(PHASE_N)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (adv)
    );

    hwctl_major_reg u_major (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .ind_bit (ind_bit),
        .irq     (irq),
        .cyc     (cyc)
    );

    hwctl_op_decode #(.OP_W(OP_W)) u_dec (
        .opcode   (opcode),
        .op_lines (op_lines)
    );

    hwctl_strobe_matrix #(.OP_W(OP_W), .PHASE_N(PHASE_N)) u_matrix (
        .cyc      (cyc),
        .phase    (phase),
        .op_lines (op_lines),
        .strb     (strb)
    );

    assign cycle    = cyc;
    assign mar_load = strb.mar_load;
    assign mbr_load = strb.mbr_load;
    assign pc_inc   = strb.pc_inc;
    assign ir_load  = strb.ir_load;
    assign acc_load = strb.acc_load;
endmodule

// File: rtl/hwctl_checker.sv
module hwctl_checker #(
    parameter int OP_W    = 4,
    parameter int PHASE_N = 4,
    localparam int PH_W   = $clog2(PHASE_N),
    localparam int NOPS   = 1 << OP_W
) (
    input logic            clk,
    input logic            rst,
    input logic            ind_bit,
    input logic            irq,
    input logic            mar_load,
    input logic            mbr_load,
    input logic            pc_inc,
    input logic            ir_load,
    input logic            acc_load,
    input logic [1:0]      cycle,
    input logic [PH_W-1:0] phase,
    input logic [NOPS-1:0] op_lines
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASE_N - 1);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST_PH) |=> (phase == $past(phase) + 1'b1) && (cycle == $past(cycle)));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST_PH) |=> (phase == '0));

    // R3
    fetch_ind_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle == 2'b00 && phase == LAST_PH && ind_bit) |=> (cycle == 2'b01));

    // R3
    fetch_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle == 2'b00 && phase == LAST_PH && !ind_bit) |=> (cycle == 2'b10));

    // R5
    exec_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle == 2'b10 && phase == LAST_PH && irq) |=> (cycle == 2'b11));

    // R5
    exec_noirq_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle == 2'b10 && phase == LAST_PH && !irq) |=> (cycle == 2'b00));

    // R4
    intr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle == 2'b11) |-> !(mar_load || mbr_load || pc_inc || ir_load || acc_load));

    // R7
    mbr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        mbr_load |-> (phase == PH_W'(1)) && (cycle != 2'b11));

    // R7
    decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(op_lines) == 1);

    // R9
    ir_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> (cycle == 2'b00) && (phase == PH_W'(2)));

    // R10
    acc_exec_chk: assert property (@(posedge clk) disable iff (rst)
        acc_load |-> (cycle == 2'b10) && (phase == PH_W'(2)));
endmodule

bind hwctl_top hwctl_checker #(.OP_W(OP_W), .PHASE_N(PHASE_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ind_bit  (ind_bit),
    .irq      (irq),
    .mar_load (mar_load),
    .mbr_load (mbr_load),
    .pc_inc   (pc_inc),
    .ir_load  (ir_load),
    .acc_load (acc_load),
    .cycle    (cycle),
    .phase    (phase),
    .op_lines (op_lines)
);

// File: tb/hwctl_top_bench.sv
`timescale 1ns/1ps
module hwctl_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = '0;
    logic       ind_bit = 1'b0;
    logic       irq = 1'b0;
    logic       mar_load, mbr_load, pc_inc, ir_load, acc_load;
    logic [1:0] cycle;
    logic [1:0] phase;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [1:0] m_cyc = 2'b00;
    int         m_ph  = 0;

    always #2.5 clk = ~clk;

    hwctl_top u_hwctl_top (
        .clk(clk), .rst(rst), .opcode(opcode), .ind_bit(ind_bit), .irq(irq),
        .mar_load(mar_load), .mbr_load(mbr_load), .pc_inc(pc_inc),
        .ir_load(ir_load), .acc_load(acc_load), .cycle(cycle), .phase(phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle model %0d, phase model %0d)",
                     tag, act, exp, m_cyc, m_ph);
        end
    endtask

    function automatic bit mem_rd(input logic [3:0] op);
        return (op == 4'd1) || (op == 4'd2) || (op == 4'd3);
    endfunction

    // compare all outputs against the model, then advance one clock
    task automatic tick(input logic [3:0] op, input logic ind, input logic req, input logic r);
        bit m, e_mar, e_mbr, e_pc, e_ir, e_acc;
        opcode = op; ind_bit = ind; irq = req; rst = r;
        #1;
        m     = mem_rd(op);
        e_mar = (m_ph == 0) && (m_cyc == 2'b00 || m_cyc == 2'b01 || (m_cyc == 2'b10 && m));
        e_mbr = (m_ph == 1) && (m_cyc == 2'b00 || m_cyc == 2'b01 || (m_cyc == 2'b10 && m));
        e_pc  = (m_cyc == 2'b00) && (m_ph == 1);
        e_ir  = (m_cyc == 2'b00) && (m_ph == 2);
        e_acc = (m_cyc == 2'b10) && (m_ph == 2) && m;
        chk("R2 R3 R4 R5 sequence", {cycle, phase}, {m_cyc, 2'(m_ph)});
        if (m_cyc == 2'b11)
            chk("R4 interrupt quiet", {mar_load, mbr_load, pc_inc, ir_load, acc_load}, 0);
        if (m_cyc == 2'b10) chk("R7 mbr execute", mbr_load, e_mbr);
        else                chk("R6 mbr fetch/indirect", mbr_load, e_mbr);
        chk("R8 mar", mar_load, e_mar);
        chk("R9 pc/ir", {pc_inc, ir_load}, {e_pc, e_ir});
        chk("R10 acc", acc_load, e_acc);
        @(posedge clk);
        if (r) begin
            m_cyc = 2'b00; m_ph = 0;
        end else if (m_ph == 3) begin
            m_ph = 0;
            case (m_cyc)
                2'b00: m_cyc = ind ? 2'b01 : 2'b10;
                2'b01: m_cyc = 2'b10;
                2'b10: m_cyc = req ? 2'b11 : 2'b00;
                default: m_cyc = 2'b00;
            endcase
        end else begin
            m_ph++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk("R1 reset cycle", cycle, 0);
        chk("R1 reset phase", phase, 0);
        rst = 1'b0;

        // sweep: every opcode x indirect x interrupt; the deciding inputs are
        // held inverted except at the T4 that samples them
        for (int op = 0; op < 16; op++) begin
            for (int ind = 0; ind < 2; ind++) begin
                for (int req = 0; req < 2; req++) begin
                    int guard = 0;
                    do begin
                        logic di, dq;
                        di = (m_cyc == 2'b00 && m_ph == 3) ? 1'(ind) : ~1'(ind);
                        dq = (m_cyc == 2'b10 && m_ph == 3) ? 1'(req) : ~1'(req);
                        tick(4'(op), di, dq, 1'b0);
                        guard++;
                    end while (!(m_cyc == 2'b00 && m_ph == 0) && guard < 32);
                end
            end
        end

        // R1: reset raised mid-instruction (execute of an indirect load)
        for (int k = 0; k < 10; k++) tick(4'd1, 1'b1, 1'b0, 1'b0);
        tick(4'd1, 1'b1, 1'b0, 1'b1);
        chk("R1 mid-run reset cycle", cycle, 0);
        chk("R1 mid-run reset phase", phase, 0);
        for (int k = 0; k < 8; k++) tick(4'd2, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule